// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block receives serial words while acting as the clock master. It generates the serial clock from the system clock through a programmable divider. It samples the data line on each falling edge of that clock and assembles 8-bit or 9-bit words, least-significant bit first. Each finished word moves into a two-entry receive queue. The consumer sees the oldest entry, including its ninth bit, on the output pins and removes it with a one-cycle pop strobe.

Reception runs in one of two modes. A one-shot request fetches exactly one word and then withdraws itself. A continuous enable keeps words coming for as long as it is held, and it overrides a one-shot request that is pending at the same time. If a word completes while both queue entries are occupied, the word is dropped and a sticky overrun flag rises. While that flag is up, no further word enters the queue. Only a high-to-low transition of the continuous enable clears it. Dropping the port enable returns everything to idle.

Top module: `sync_master_rx`

## Requirements
- R1: The serial clock toggles only while `port_en` is high and either `cont_en` is high or a one-shot request is pending. It sits low otherwise.
- R2: While running, each high phase and each low phase of `sclk_out` lasts `div_val`+1 system clock cycles, and the first rising edge follows enable by the same amount.
- R3: `sdata_in` is sampled on each falling edge of `sclk_out`, least-significant bit first. A word has 8 bits, or 9 when `nine_bit` is high. The ninth sample appears on `rx_bit9`, which reads 0 for words taken in 8-bit mode.
- R4: The queue holds two words in arrival order. `rx_ready` is high exactly while the queue is non-empty. `rx_ready` stays high until pops have emptied the queue. A pop on an empty queue has no effect.
- R5: A `single_go` pulse with `cont_en` low receives exactly one word. After that word, `single_busy` returns to 0 and the serial clock stops.
- R6: With `cont_en` high, reception continues past the first word even if a one-shot request is pending, and `single_busy` stays set.
- R7: A word that completes while the queue holds two entries is discarded, and `overrun` goes high. The queued words are kept.
- R8: While `overrun` is high, no completed word enters the queue, even when the queue has room. A falling edge of `cont_en` clears `overrun` on the next cycle.
- R9: `rx_bit9` and `rx_data` always show the head entry. A pop moves both to the next entry.
- R10: Driving `port_en` low empties the queue, clears `overrun` and `single_busy`, and halts the clock and the bit counter.
- R11: After reset, `sclk_out`, `rx_ready`, `overrun` and `single_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 1 | Serial port enable; low flushes and idles |
| cont_en | input | 1 | Continuous reception enable |
| single_go | input | 1 | One-cycle pulse requesting one word |
| nine_bit | input | 1 | 1 selects 9-bit words |
| div_val | input | DIV_W | Half-period of serial clock minus one |
| sdata_in | input | 1 | Serial data line |
| rd_pop | input | 1 | Remove the head entry of the queue |
| sclk_out | output | 1 | Generated serial clock, idles low |
| rx_data | output | 8 | Head entry data |
| rx_bit9 | output | 1 | Head entry ninth bit |
| rx_ready | output | 1 | Queue non-empty |
| overrun | output | 1 | Sticky overrun flag |
| single_busy | output | 1 | One-shot request pending |

## Verification
Continuous streams of 8-bit words use alternating, all-ones, all-zero and edge-bit patterns. These show whether the bit order or the bit count is wrong. Nine-bit streams with differing top bits show whether the ninth bit stays paired with its own word across a pop. A five-word burst with no pops separates discarding the third word from overwriting a queued one. Popping afterwards while zeros keep streaming shows whether a raised overrun really blocks further writes. Single-shot, combined-enable and divider-length runs cover the mode precedence and the clock timing.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_DATA_W = 8;

  typedef struct packed {
    logic                  b9;
    logic [SRX_DATA_W-1:0] data;
  } srx_word_t;
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             sclk,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick     = (cnt_q >= div_val);
  assign fall_stb = run && tick && sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sample_stb,
  input  logic              sdata,
  input  logic              nine,
  output logic              word_stb,
  output logic [DATA_W-1:0] word_data,
  output logic              word_b9
);
  localparam int MAX_BITS = DATA_W + 1;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);

  logic [MAX_BITS-1:0] shreg_q;
  logic [MAX_BITS-1:0] merged;
  logic [CNT_W-1:0]    bitcnt_q;
  logic [CNT_W-1:0]    last_idx;
  logic                last;

  assign last_idx = nine ? CNT_W'(MAX_BITS - 1) : CNT_W'(DATA_W - 1);
  assign last     = (bitcnt_q == last_idx);

  always_comb begin
    merged           = shreg_q;
    merged[bitcnt_q] = sdata;
  end

  assign word_stb  = run && sample_stb && last;
  assign word_data = merged[DATA_W-1:0];
  assign word_b9   = nine & merged[DATA_W];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bitcnt_q <= '0;
    end else if (sample_stb) begin
      bitcnt_q <= last ? '0 : bitcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (run && sample_stb) shreg_q <= merged;
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 9,
  parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign count   = cnt_q;
  assign head    = mem[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx
  import srx_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  port_en,
  input  logic                  cont_en,
  input  logic                  single_go,
  input  logic                  nine_bit,
  input  logic [DIV_W-1:0]      div_val,
  input  logic                  sdata_in,
  input  logic                  rd_pop,
  output logic                  sclk_out,
  output logic [SRX_DATA_W-1:0] rx_data,
  output logic                  rx_bit9,
  output logic                  rx_ready,
  output logic                  overrun,
  output logic                  single_busy
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int WORD_W = $bits(srx_word_t);

  logic                  single_q, cont_q, overrun_q;
  logic                  run, fall_stb, word_stb, word_b9;
  logic [SRX_DATA_W-1:0] word_data;
  logic                  fifo_full, fifo_empty, push;
  logic [CNT_W-1:0]      fifo_count;
  srx_word_t             in_word, head_word;

  assign run = port_en && (cont_en || single_q);

  srx_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .div_val(div_val),
    .sclk(sclk_out), .fall_stb(fall_stb)
  );

  srx_shifter #(.DATA_W(SRX_DATA_W)) u_shift (
    .clk(clk), .rst(rst), .run(run), .sample_stb(fall_stb),
    .sdata(sdata_in), .nine(nine_bit), .word_stb(word_stb),
    .word_data(word_data), .word_b9(word_b9)
  );

  assign in_word.b9   = word_b9;
  assign in_word.data = word_data;
  assign push         = word_stb && !overrun_q && !fifo_full;

  srx_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .clear(!port_en), .push(push),
    .push_data(in_word), .pop(rd_pop), .head(head_word),
    .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  always_ff @(posedge clk) begin
    if (rst || !port_en)             single_q <= 1'b0;
    else if (single_go)              single_q <= 1'b1;
    else if (word_stb && !cont_en)   single_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) cont_q <= 1'b0;
    else     cont_q <= cont_en;
  end

  always_ff @(posedge clk) begin
    if (rst || !port_en)                         overrun_q <= 1'b0;
    else if (cont_q && !cont_en)                 overrun_q <= 1'b0;
    else if (word_stb && fifo_full)              overrun_q <= 1'b1;
  end

  assign rx_data     = head_word.data;
  assign rx_bit9     = head_word.b9;
  assign rx_ready    = !fifo_empty;
  assign overrun     = overrun_q;
  assign single_busy = single_q;
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
  parameter int CNT_W = 2,
  parameter int DEPTH = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             port_en,
  input logic             cont_en,
  input logic             rd_pop,
  input logic             sclk_out,
  input logic             rx_ready,
  input logic             overrun,
  input logic             single_busy,
  input logic [CNT_W-1:0] fifo_count
);
  a_r1_idle_clock: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> !sclk_out);

  a_r4_ready_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_ready && !rd_pop && port_en) |=> rx_ready);

  a_r4_depth: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));

  a_r7_overrun_full: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> (fifo_count == CNT_W'(DEPTH)));

  a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    (overrun && cont_en && port_en) |=> overrun);

  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(cont_en) |=> !overrun);

  a_r10_flush: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!rx_ready && !overrun && !single_busy));
endmodule

bind sync_master_rx srx_checker #(.CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .port_en(port_en), .cont_en(cont_en),
  .rd_pop(rd_pop), .sclk_out(sclk_out), .rx_ready(rx_ready),
  .overrun(overrun), .single_busy(single_busy), .fifo_count(fifo_count)
);

// File: tb/sync_master_rx_tb.sv
module sync_master_rx_tb;
  logic clk = 0, rst = 1;
  logic port_en = 0, cont_en = 0, single_go = 0, nine_bit = 0;
  logic [7:0] div_val = 8'd2;
  logic sdata_in = 0, rd_pop_auto = 0, rd_pop_man = 0, auto_pop = 1;
  logic sclk_out, rx_bit9, rx_ready, overrun, single_busy, sclk_prev = 0;
  logic [7:0] rx_data;
  logic rd_pop;
  int n_chk = 0, n_bad = 0;
  logic bitq[$];
  logic [8:0] expq[$];

  assign rd_pop = rd_pop_auto | rd_pop_man;
  always #4 clk = ~clk;

  sync_master_rx u_dut (
    .clk(clk), .rst(rst), .port_en(port_en), .cont_en(cont_en),
    .single_go(single_go), .nine_bit(nine_bit), .div_val(div_val),
    .sdata_in(sdata_in), .rd_pop(rd_pop), .sclk_out(sclk_out),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .rx_ready(rx_ready),
    .overrun(overrun), .single_busy(single_busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // serial source: a new bit after each rising serial clock edge
  always @(negedge clk) begin
    if (sclk_out && !sclk_prev) sdata_in = (bitq.size() != 0) ? bitq.pop_front() : 1'b0;
    sclk_prev = sclk_out;
  end

  // monitor: pops and compares against the scoreboard queue
  always @(negedge clk) begin
    if (rd_pop_auto) rd_pop_auto = 0;
    else if (auto_pop && rx_ready) begin
      if (expq.size() == 0) chk(0, "R4", "unexpected word", {rx_bit9, rx_data}, 0);
      else begin
        logic [8:0] e;
        e = expq.pop_front();
        chk({rx_bit9, rx_data} == e, "R3", "received word", {rx_bit9, rx_data}, e);
      end
      rd_pop_auto = 1;
    end
  end

  task automatic send(input logic [7:0] d, input logic b9, input bit expect_it);
    for (int i = 0; i < 8; i++) bitq.push_back(d[i]);
    if (nine_bit) bitq.push_back(b9);
    if (expect_it) expq.push_back({b9 & nine_bit, d});
  endtask

  task automatic finish_stream();
    while (bitq.size() != 0) @(negedge clk);
    @(negedge sclk_out);
    @(negedge clk);
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic man_pop();
    @(negedge clk) rd_pop_man = 1;
    @(negedge clk) rd_pop_man = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(sclk_out == 0, "R11", "sclk after reset", sclk_out, 0);
    chk(rx_ready == 0, "R11", "ready after reset", rx_ready, 0);
    chk(overrun == 0, "R11", "overrun after reset", overrun, 0);
    chk(single_busy == 0, "R11", "single after reset", single_busy, 0);
    port_en = 1;
    repeat (10) @(negedge clk);
    chk(sclk_out == 0, "R1", "clock idle with no enable", sclk_out, 0);

    // R3 continuous 8-bit patterns
    cont_en = 1;
    send(8'hA5, 0, 1); send(8'h3C, 0, 1); send(8'hFF, 0, 1);
    send(8'h00, 0, 1); send(8'h81, 0, 1);
    finish_stream(); cont_en = 0; drain();

    // R3 nine-bit mode
    nine_bit = 1; cont_en = 1;
    send(8'h5A, 1, 1); send(8'hC3, 0, 1); send(8'h01, 1, 1);
    finish_stream(); cont_en = 0; drain();

    // R9 ninth bit follows the head
    auto_pop = 0; cont_en = 1;
    send(8'h12, 1, 0); send(8'h34, 0, 0);
    finish_stream(); cont_en = 0; repeat (2) @(negedge clk);
    chk(rx_bit9 == 1 && rx_data == 8'h12, "R9", "head before pop", {rx_bit9, rx_data}, 9'h112);
    man_pop();
    chk(rx_bit9 == 0 && rx_data == 8'h34, "R9", "head after pop", {rx_bit9, rx_data}, 9'h034);
    man_pop();
    chk(rx_ready == 0, "R4", "ready after emptying", rx_ready, 0);
    nine_bit = 0;

    // R5 single word
    auto_pop = 1;
    @(negedge clk) single_go = 1;
    @(negedge clk) single_go = 0;
    chk(single_busy == 1, "R5", "single pending", single_busy, 1);
    send(8'h6E, 0, 1);
    finish_stream();
    chk(single_busy == 0, "R5", "single self-clear", single_busy, 0);
    hi = 0;
    repeat (40) @(negedge clk) if (sclk_out) hi++;
    chk(hi == 0, "R5", "clock stopped after single", hi, 0);
    drain();

    // R6 continuous overrides single
    cont_en = 1;
    @(negedge clk) single_go = 1;
    @(negedge clk) single_go = 0;
    send(8'h11, 0, 1); send(8'h22, 0, 1); send(8'h33, 0, 1);
    finish_stream(); drain();
    chk(single_busy == 1, "R6", "single still pending", single_busy, 1);
    port_en = 0; cont_en = 0;
    @(negedge clk);
    chk(single_busy == 0, "R10", "single flushed", single_busy, 0);
    port_en = 1;

    // R7 / R8 overrun
    auto_pop = 0; cont_en = 1;
    send(8'hC1, 0, 0); send(8'hC2, 0, 0); send(8'hC3, 0, 0);
    send(8'hC4, 0, 0); send(8'hC5, 0, 0);
    finish_stream();
    chk(overrun == 1, "R7", "overrun set", overrun, 1);
    chk(rx_data == 8'hC1, "R7", "head kept", rx_data, 8'hC1);
    man_pop();
    chk(rx_data == 8'hC2, "R7", "second kept", rx_data, 8'hC2);
    man_pop();
    chk(rx_ready == 0, "R4", "empty after two pops", rx_ready, 0);
    repeat (150) @(negedge clk);
    chk(rx_ready == 0, "R8", "no writes while overrun", rx_ready, 0);
    chk(overrun == 1, "R8", "overrun sticky", overrun, 1);
    cont_en = 0;
    repeat (2) @(negedge clk);
    chk(overrun == 0, "R8", "overrun cleared by cont fall", overrun, 0);

    // R10 flush and R4 pop-on-empty
    cont_en = 1;
    send(8'h99, 0, 0);
    finish_stream(); cont_en = 0; repeat (2) @(negedge clk);
    chk(rx_ready == 1, "R4", "ready with one word", rx_ready, 1);
    port_en = 0; @(negedge clk); port_en = 1; @(negedge clk);
    chk(rx_ready == 0, "R10", "queue flushed", rx_ready, 0);
    man_pop();
    chk(rx_ready == 0, "R4", "pop on empty ignored", rx_ready, 0);
    auto_pop = 1; cont_en = 1;
    send(8'h5C, 0, 1);
    finish_stream(); cont_en = 0; drain();

    // R2 divider
    for (int k = 0; k < 2; k++) begin
      div_val = (k == 0) ? 8'd5 : 8'd0;
      cont_en = 1;
      @(posedge sclk_out);
      hi = 0;
      @(negedge clk);
      while (sclk_out) begin hi++; @(negedge clk); end
      cont_en = 0;
      chk(hi == div_val + 1, "R2", "high phase length", hi, div_val + 1);
      repeat (3) @(negedge clk);
    end
    chk(expq.size() == 0, "R4", "all words seen", expq.size(), 0);
    summary();
  end
endmodule